// File: doc/BRIEF.md
# NOR Flash Array Controller with Erase Sequencer

This block owns a small on-chip NOR-style flash array and a user-configuration word area. It keeps both as word-addressed register arrays, and it controls programming and erasure through a memory-mapped control window. Software first sets a write-permit bit and an erase-permit bit in a configuration register. It then programs flash words through a dedicated write port. A program operation can only pull bits from 1 to 0, as on real NOR cells.

Erasure covers three scopes: one page, the whole array (which also wipes the user area), or just the user area. Each scope has its own command register and its own acceptance rules. An accepted erase walks the target words one per clock. During that time a ready flag reads 0 and every incoming bus write is discarded.

The user-configuration area is read and written freely through its own window. Reset clears the configuration register and fills the user area with ones. Reset leaves the flash contents as they are.

Top module: `nvm_flash_ctrl`

## Requirements
- R1: The configuration register at control offset 0x504 keeps only bit 0 (write permit) and bit 1 (erase permit) of a write and reads back those two bits in the same positions. Reads of unmapped control offsets return 0.
- R2: A flash-port write while the write permit is set stores old AND new into the addressed word. Without the write permit the word keeps its previous value.
- R3: With the erase permit set, a write to offset 0x508 or 0x510 zeroes the value's in-page offset bits. If the resulting page start is at most FLASH_BYTES-PAGE_BYTES, that page is filled with all-ones. Other pages are not changed.
- R4: A page-erase write made while the erase permit is clear, or naming a page start beyond the last page, changes nothing and does not make the block busy.
- R5: Writing value 1 to offset 0x50C with the erase permit set fills every flash word and every user word with all-ones. With the erase permit clear, the write has no effect.
- R6: Writing value 1 to offset 0x514 fills every user word with all-ones whatever the erase permit is. Any other value has no effect.
- R7: User words are read and written through the user window, one 32-bit word per word address.
- R8: Reset sets the configuration register to 0 and every user word to all-ones, and leaves flash words unchanged.
- R9: Offset 0x400 reads 1 when idle and 0 while an erase runs. A page erase keeps the block busy for exactly PAGE_BYTES/4 cycles, and every erase walks one word per clock.
- R10: Control, user-window and flash-port writes that arrive while an erase runs are ignored.
- R11: Writes to unmapped control offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWe | input | 1 | Control window write strobe |
| ctlAddr | input | 12 | Control window byte offset |
| ctlWdata | input | 32 | Control window write data |
| ctlRdata | output | 32 | Control window read data (combinational) |
| ucWe | input | 1 | User window write strobe |
| ucAddr | input | $clog2(UC_WORDS) | User window word address |
| ucWdata | input | 32 | User window write data |
| ucRdata | output | 32 | User word at ucAddr |
| flWe | input | 1 | Flash program strobe |
| flAddr | input | $clog2(FLASH_BYTES/4) | Flash word address for program and read |
| flWdata | input | 32 | Flash program data |
| flRdata | output | 32 | Flash word at flAddr |

## Verification
On every cycle the assertions check three things. Programming never raises a bit. A fill strobe leaves its target word all-ones. The erase walk counter stays inside its window and returns the block to idle. They also check that the configuration register cannot change while busy, and that erase commands start or fail to start according to the permit bits. Other behaviour shows only in the bench's scenarios: that the correct page is chosen after offset masking, that the last-page boundary is accepted, that the user area is also wiped by a whole-array erase, and that flash contents survive reset. Those scenarios read the array contents back afterwards.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  // Strobes from the control unit to the storage datapath
  typedef struct packed {
    logic flProg;   // AND-program one flash word from the write port
    logic ucWrite;  // plain write of one user word
    logic flFill;   // set one flash word to all-ones (erase walk)
    logic ucFill;   // set one user word to all-ones (erase walk)
  } nvm_strobe_t;

  typedef enum logic [1:0] {
    OP_PAGE = 2'd0,
    OP_ALL  = 2'd1,
    OP_UC   = 2'd2
  } erase_op_e;

  localparam logic [11:0] OFS_READY     = 12'h400;
  localparam logic [11:0] OFS_CONFIG    = 12'h504;
  localparam logic [11:0] OFS_PAGE_A    = 12'h508;
  localparam logic [11:0] OFS_ERASE_ALL = 12'h50C;
  localparam logic [11:0] OFS_PAGE_B    = 12'h510;
  localparam logic [11:0] OFS_ERASE_UC  = 12'h514;

  localparam int          CFG_WEN_BIT = 0;
  localparam int          CFG_EEN_BIT = 1;
  localparam logic [31:0] ERASE_CODE  = 32'h0000_0001;

endpackage

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int FLASH_BYTES = 4096,
  parameter int PAGE_BYTES  = 1024,
  parameter int UC_WORDS    = 64,
  localparam int FLASH_WORDS = FLASH_BYTES / 4,
  localparam int FL_IDX_W    = $clog2(FLASH_WORDS),
  localparam int UC_IDX_W    = $clog2(UC_WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctlWe,
  input  logic [11:0]         ctlAddr,
  input  logic [31:0]         ctlWdata,
  output logic [31:0]         ctlRdata,
  input  logic                ucWe,
  input  logic                flWe,
  output nvm_strobe_t         strobe,
  output logic [FL_IDX_W-1:0] fillFlIdx,
  output logic [UC_IDX_W-1:0] fillUcIdx
);

  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int MAX_WORDS  = (FLASH_WORDS > UC_WORDS) ? FLASH_WORDS : UC_WORDS;
  localparam int CNT_W      = $clog2(MAX_WORDS) + 1;

  localparam logic [31:0]      PAGE_MASK  = 32'(PAGE_BYTES - 1);
  localparam logic [31:0]      LAST_PAGE  = 32'(FLASH_BYTES - PAGE_BYTES);
  localparam logic [CNT_W-1:0] FL_CNT     = CNT_W'(FLASH_WORDS);
  localparam logic [CNT_W-1:0] UC_CNT     = CNT_W'(UC_WORDS);
  localparam logic [CNT_W-1:0] LAST_PAGEW = CNT_W'(PAGE_WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_ALL   = CNT_W'(MAX_WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_UC    = CNT_W'(UC_WORDS - 1);

  logic [1:0]          cfgReg;
  logic                busy;
  erase_op_e           curOp;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    lastCnt;
  logic [FL_IDX_W-1:0] baseIdx;

  logic        accept;
  logic        isPage;
  logic [31:0] pageStart;
  logic        pageInRange;
  logic        startPage;
  logic        startAll;
  logic        startUc;

  // Command decode: nothing is accepted while an erase walk runs
  assign accept      = ctlWe && !busy;
  assign isPage      = (ctlAddr == OFS_PAGE_A) || (ctlAddr == OFS_PAGE_B);
  assign pageStart   = ctlWdata & ~PAGE_MASK;
  assign pageInRange = (pageStart <= LAST_PAGE);
  assign startPage   = accept && isPage && cfgReg[CFG_EEN_BIT] && pageInRange;
  assign startAll    = accept && (ctlAddr == OFS_ERASE_ALL) &&
                       (ctlWdata == ERASE_CODE) && cfgReg[CFG_EEN_BIT];
  assign startUc     = accept && (ctlAddr == OFS_ERASE_UC) &&
                       (ctlWdata == ERASE_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= 2'b00;
    end else if (accept && (ctlAddr == OFS_CONFIG)) begin
      cfgReg <= ctlWdata[1:0];
    end
  end

  // Erase walk sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      curOp   <= OP_PAGE;
      cnt     <= '0;
      lastCnt <= '0;
      baseIdx <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == lastCnt) begin
        busy <= 1'b0;
      end
    end else if (startPage) begin
      busy    <= 1'b1;
      curOp   <= OP_PAGE;
      cnt     <= '0;
      lastCnt <= LAST_PAGEW;
      baseIdx <= pageStart[FL_IDX_W+1:2];
    end else if (startAll) begin
      busy    <= 1'b1;
      curOp   <= OP_ALL;
      cnt     <= '0;
      lastCnt <= LAST_ALL;
      baseIdx <= '0;
    end else if (startUc) begin
      busy    <= 1'b1;
      curOp   <= OP_UC;
      cnt     <= '0;
      lastCnt <= LAST_UC;
      baseIdx <= '0;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.flProg  = flWe && !busy && cfgReg[CFG_WEN_BIT];
    strobe.ucWrite = ucWe && !busy;
    strobe.flFill  = busy && ((curOp == OP_PAGE) ||
                              ((curOp == OP_ALL) && (cnt < FL_CNT)));
    strobe.ucFill  = busy && ((curOp == OP_UC) ||
                              ((curOp == OP_ALL) && (cnt < UC_CNT)));
  end

  assign fillFlIdx = baseIdx + cnt[FL_IDX_W-1:0];
  assign fillUcIdx = cnt[UC_IDX_W-1:0];

  always_comb begin
    ctlRdata = 32'd0;
    if (ctlAddr == OFS_READY) begin
      ctlRdata = {31'd0, !busy};
    end else if (ctlAddr == OFS_CONFIG) begin
      ctlRdata = {30'd0, cfgReg};
    end
  end

  // R10: configuration cannot move while the walk runs
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cfgReg));

  // R4: page erase without erase permit never starts a walk
  p_page_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && !busy && isPage && !cfgReg[CFG_EEN_BIT]) |=> !busy);

  // R5: whole-array erase without erase permit never starts a walk
  p_all_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && !busy && (ctlAddr == OFS_ERASE_ALL) && !cfgReg[CFG_EEN_BIT]) |=> !busy);

  // R6: user-area erase starts regardless of the permit bits
  p_uc_ungated_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && !busy && (ctlAddr == OFS_ERASE_UC) && (ctlWdata == ERASE_CODE))
      |=> (busy && (curOp == OP_UC) && (cnt == '0)));

  // R9: the walk stays inside its window and ends on its last word
  p_walk_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt <= lastCnt));

  p_walk_ends_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (cnt == lastCnt)) |=> !busy);

endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int FLASH_WORDS = 1024,
  parameter int UC_WORDS    = 64,
  localparam int FL_IDX_W   = $clog2(FLASH_WORDS),
  localparam int UC_IDX_W   = $clog2(UC_WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  nvm_strobe_t         strobe,
  input  logic [FL_IDX_W-1:0] flIdx,
  input  logic [31:0]         flWdata,
  input  logic [FL_IDX_W-1:0] fillFlIdx,
  input  logic [UC_IDX_W-1:0] ucIdx,
  input  logic [31:0]         ucWdata,
  input  logic [UC_IDX_W-1:0] fillUcIdx,
  output logic [31:0]         flRdata,
  output logic [31:0]         ucRdata
);

  logic [31:0] flMem [FLASH_WORDS];
  logic [31:0] ucMem [UC_WORDS];
  logic [31:0] progOld;

  assign progOld = flMem[flIdx];

  // Flash cells are not touched by reset
  always_ff @(posedge clk) begin
    if (strobe.flFill) begin
      flMem[fillFlIdx] <= '1;
    end else if (strobe.flProg) begin
      flMem[flIdx] <= progOld & flWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < UC_WORDS; i++) begin
        ucMem[i] <= '1;
      end
    end else if (strobe.ucFill) begin
      ucMem[fillUcIdx] <= '1;
    end else if (strobe.ucWrite) begin
      ucMem[ucIdx] <= ucWdata;
    end
  end

  assign flRdata = flMem[flIdx];
  assign ucRdata = ucMem[ucIdx];

  // R2: programming may only drop bits of the addressed word
  p_prog_only_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flProg && !strobe.flFill) |=>
      ((flMem[$past(flIdx)] & ~$past(progOld)) == 32'd0));

  // R3: a flash fill leaves its target word erased
  p_fill_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flFill |=> (flMem[$past(fillFlIdx)] == 32'hFFFF_FFFF));

  // R6: a user fill leaves its target word erased
  p_ucfill_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ucFill |=> (ucMem[$past(fillUcIdx)] == 32'hFFFF_FFFF));

endmodule

// File: rtl/nvm_flash_ctrl.sv
module nvm_flash_ctrl
  import nvm_pkg::*;
#(
  parameter int FLASH_BYTES = 4096,
  parameter int PAGE_BYTES  = 1024,
  parameter int UC_WORDS    = 64,
  localparam int FLASH_WORDS = FLASH_BYTES / 4,
  localparam int FL_IDX_W    = $clog2(FLASH_WORDS),
  localparam int UC_IDX_W    = $clog2(UC_WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctlWe,
  input  logic [11:0]         ctlAddr,
  input  logic [31:0]         ctlWdata,
  output logic [31:0]         ctlRdata,
  input  logic                ucWe,
  input  logic [UC_IDX_W-1:0] ucAddr,
  input  logic [31:0]         ucWdata,
  output logic [31:0]         ucRdata,
  input  logic                flWe,
  input  logic [FL_IDX_W-1:0] flAddr,
  input  logic [31:0]         flWdata,
  output logic [31:0]         flRdata
);

  nvm_strobe_t         strobe;
  logic [FL_IDX_W-1:0] fillFlIdx;
  logic [UC_IDX_W-1:0] fillUcIdx;

  nvm_ctrl #(
    .FLASH_BYTES(FLASH_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .UC_WORDS   (UC_WORDS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWe    (ctlWe),
    .ctlAddr  (ctlAddr),
    .ctlWdata (ctlWdata),
    .ctlRdata (ctlRdata),
    .ucWe     (ucWe),
    .flWe     (flWe),
    .strobe   (strobe),
    .fillFlIdx(fillFlIdx),
    .fillUcIdx(fillUcIdx)
  );

  nvm_datapath #(
    .FLASH_WORDS(FLASH_WORDS),
    .UC_WORDS   (UC_WORDS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .flIdx    (flAddr),
    .flWdata  (flWdata),
    .fillFlIdx(fillFlIdx),
    .ucIdx    (ucAddr),
    .ucWdata  (ucWdata),
    .fillUcIdx(fillUcIdx),
    .flRdata  (flRdata),
    .ucRdata  (ucRdata)
  );

endmodule

// File: tb/nvm_flash_ctrl_tb.sv
module nvm_flash_ctrl_tb;

  localparam int FLASH_BYTES = 128;
  localparam int PAGE_BYTES  = 16;
  localparam int UC_WORDS    = 8;
  localparam int FL_IDX_W    = $clog2(FLASH_BYTES / 4);
  localparam int UC_IDX_W    = $clog2(UC_WORDS);
  localparam int PAGE_WORDS  = PAGE_BYTES / 4;

  localparam logic [2:0] CW = 3'd0, CR = 3'd1, UW = 3'd2, UR = 3'd3,
                         FW = 3'd4, FR = 3'd5, ID = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t VEC [NV] = '{
    '{UR, 12'h000, 32'hFFFFFFFF, 4'd8},  // R8 user area after reset
    '{CR, 12'h504, 32'h00000000, 4'd8},  // R8 config after reset
    '{CR, 12'h400, 32'h00000001, 4'd9},  // R9 idle ready
    '{UW, 12'h000, 32'h00000000, 4'd7},  // R7
    '{UR, 12'h000, 32'h00000000, 4'd7},  // R7
    '{CW, 12'h504, 32'hFFFFFFFF, 4'd1},  // R1 masked
    '{CR, 12'h504, 32'h00000003, 4'd1},  // R1
    '{CR, 12'h100, 32'h00000000, 4'd1},  // R1 unmapped read
    '{CW, 12'h50C, 32'h00000001, 4'd5},  // R5 erase all
    '{ID, 12'h000, 32'h00000000, 4'd5},
    '{FR, 12'h000, 32'hFFFFFFFF, 4'd5},  // R5
    '{FR, 12'h07C, 32'hFFFFFFFF, 4'd5},  // R5 last word
    '{UR, 12'h000, 32'hFFFFFFFF, 4'd5},  // R5 user area too
    '{CW, 12'h504, 32'h00000001, 4'd2},  // R2 write permit only
    '{FW, 12'h000, 32'hF0F0FFFF, 4'd2},
    '{FW, 12'h000, 32'hFF00FF0F, 4'd2},
    '{FR, 12'h000, 32'hF000FF0F, 4'd2},  // R2 AND of both
    '{FW, 12'h020, 32'h12345678, 4'd2},
    '{FW, 12'h070, 32'h00000000, 4'd2},
    '{CW, 12'h504, 32'h00000000, 4'd2},
    '{FW, 12'h020, 32'h00000000, 4'd2},  // R2 dropped
    '{FR, 12'h020, 32'h12345678, 4'd2},  // R2
    '{CW, 12'h504, 32'h00000002, 4'd3},  // R3 erase permit only
    '{CW, 12'h508, 32'h00000023, 4'd3},  // R3 offset bits masked
    '{ID, 12'h000, 32'h00000000, 4'd3},
    '{FR, 12'h020, 32'hFFFFFFFF, 4'd3},  // R3
    '{FR, 12'h000, 32'hF000FF0F, 4'd3},  // R3 other page kept
    '{CW, 12'h510, 32'h00000080, 4'd4},  // R4 beyond array
    '{CR, 12'h400, 32'h00000001, 4'd4},  // R4 no walk started
    '{FR, 12'h070, 32'h00000000, 4'd4},  // R4
    '{CW, 12'h510, 32'h0000007C, 4'd3},  // R3 last page via second register
    '{ID, 12'h000, 32'h00000000, 4'd3},
    '{FR, 12'h070, 32'hFFFFFFFF, 4'd3},  // R3
    '{UW, 12'h008, 32'hCAFEF00D, 4'd7},  // R7
    '{UR, 12'h008, 32'hCAFEF00D, 4'd7},  // R7
    '{UR, 12'h00C, 32'hFFFFFFFF, 4'd7},  // R7 neighbour
    '{CW, 12'h504, 32'h00000000, 4'd6},
    '{CW, 12'h514, 32'h00000002, 4'd6},  // R6 wrong code
    '{UR, 12'h008, 32'hCAFEF00D, 4'd6},  // R6
    '{CW, 12'h514, 32'h00000001, 4'd6},  // R6 no permit needed
    '{ID, 12'h000, 32'h00000000, 4'd6},
    '{UR, 12'h008, 32'hFFFFFFFF, 4'd6},  // R6
    '{CW, 12'h508, 32'h00000000, 4'd4},  // R4 permit clear
    '{ID, 12'h000, 32'h00000000, 4'd4},
    '{FR, 12'h000, 32'hF000FF0F, 4'd4},  // R4
    '{CW, 12'h50C, 32'h00000001, 4'd5},  // R5 permit clear
    '{ID, 12'h000, 32'h00000000, 4'd5},
    '{FR, 12'h000, 32'hF000FF0F, 4'd5},  // R5 gated
    '{CW, 12'h600, 32'h00000003, 4'd11}, // R11 unmapped write
    '{CR, 12'h504, 32'h00000000, 4'd11}, // R11 config untouched
    '{CR, 12'h600, 32'h00000000, 4'd11}  // R11
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                ctlWe = 1'b0;
  logic [11:0]         ctlAddr = '0;
  logic [31:0]         ctlWdata = '0;
  logic [31:0]         ctlRdata;
  logic                ucWe = 1'b0;
  logic [UC_IDX_W-1:0] ucAddr = '0;
  logic [31:0]         ucWdata = '0;
  logic [31:0]         ucRdata;
  logic                flWe = 1'b0;
  logic [FL_IDX_W-1:0] flAddr = '0;
  logic [31:0]         flWdata = '0;
  logic [31:0]         flRdata;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nvm_flash_ctrl #(
    .FLASH_BYTES(FLASH_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .UC_WORDS   (UC_WORDS)
  ) u_dut (
    .clk(clk), .rstN(rstN),
    .ctlWe(ctlWe), .ctlAddr(ctlAddr), .ctlWdata(ctlWdata), .ctlRdata(ctlRdata),
    .ucWe(ucWe), .ucAddr(ucAddr), .ucWdata(ucWdata), .ucRdata(ucRdata),
    .flWe(flWe), .flAddr(flAddr), .flWdata(flWdata), .flRdata(flRdata)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    ctlAddr = a; ctlWdata = d; ctlWe = 1'b1;
    @(negedge clk);
    ctlWe = 1'b0;
  endtask

  task automatic ctlRead(input int req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    ctlAddr = a;
    #1 chk(req, ctlRdata, exp);
  endtask

  task automatic ucWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    ucAddr = a[UC_IDX_W+1:2]; ucWdata = d; ucWe = 1'b1;
    @(negedge clk);
    ucWe = 1'b0;
  endtask

  task automatic ucRead(input int req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    ucAddr = a[UC_IDX_W+1:2];
    #1 chk(req, ucRdata, exp);
  endtask

  task automatic flWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    flAddr = a[FL_IDX_W+1:2]; flWdata = d; flWe = 1'b1;
    @(negedge clk);
    flWe = 1'b0;
  endtask

  task automatic flRead(input int req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    flAddr = a[FL_IDX_W+1:2];
    #1 chk(req, flRdata, exp);
  endtask

  task automatic waitIdle(input int req);
    int n;
    n = 0;
    ctlAddr = 12'h400;
    #1;
    while (ctlRdata[0] !== 1'b1 && n < 500) begin
      @(negedge clk);
      #1;
      n++;
    end
    if (n >= 500) chk(req, ctlRdata, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        CW: ctlWrite(VEC[i].addr, VEC[i].data);
        CR: ctlRead(int'(VEC[i].req), VEC[i].addr, VEC[i].data);
        UW: ucWrite(VEC[i].addr, VEC[i].data);
        UR: ucRead(int'(VEC[i].req), VEC[i].addr, VEC[i].data);
        FW: flWrite(VEC[i].addr, VEC[i].data);
        FR: flRead(int'(VEC[i].req), VEC[i].addr, VEC[i].data);
        default: waitIdle(int'(VEC[i].req));
      endcase
    end

    // R9: page erase busy for exactly PAGE_WORDS cycles
    ctlWrite(12'h504, 32'h2);
    ctlWrite(12'h508, 32'h40);
    ctlAddr = 12'h400;
    #1 chk(9, ctlRdata, 32'h0);
    for (int k = 0; k < PAGE_WORDS - 1; k++) @(negedge clk);
    #1 chk(9, ctlRdata, 32'h0);
    @(negedge clk);
    #1 chk(9, ctlRdata, 32'h1);

    // R10: writes during a walk are dropped on every window
    ctlWrite(12'h504, 32'h3);
    ctlWrite(12'h508, 32'h40);
    @(negedge clk);
    ctlAddr = 12'h504; ctlWdata = 32'h0; ctlWe = 1'b1;
    ucAddr = 3'd1; ucWdata = 32'h55; ucWe = 1'b1;
    flAddr = FL_IDX_W'(12'h50 >> 2); flWdata = 32'h0; flWe = 1'b1;
    @(negedge clk);
    ctlWe = 1'b0; ucWe = 1'b0; flWe = 1'b0;
    waitIdle(10);
    ctlRead(10, 12'h504, 32'h3);    // R10 config kept
    ucRead(10, 12'h004, 32'hFFFFFFFF); // R10 user word kept
    flRead(10, 12'h050, 32'hFFFFFFFF); // R10 flash word kept

    // R8: reset clears config and user area, keeps flash
    flWrite(12'h054, 32'h000000AB);
    ucWrite(12'h014, 32'h00001234);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    ctlRead(8, 12'h504, 32'h0);
    ucRead(8, 12'h014, 32'hFFFFFFFF);
    flRead(8, 12'h054, 32'h000000AB);
    ctlRead(8, 12'h400, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule